// File: doc/BRIEF.md
# Per-Port Compare Unit with Auto-Increment

This block gives one processor port a private alarm on a free-running 64-bit count that is shared by all ports. It holds a 64-bit comparator, a 32-bit step and a sticky event flag. Each cycle it compares the shared count against the comparator. The comparison runs only while the global timer enable input and this port's comparator enable are both set. When the count has gone strictly past the comparator, the event flag is set. If auto-increment is enabled and the step is nonzero, the comparator also jumps forward by the smallest multiple of the step that brings it level with, or beyond, the current count. The interrupt output is the event flag masked by the port's interrupt enable.

Software programs the unit through a simple write port: a write strobe, a 3-bit register select and 32 bits of data. The register contents come back on plain outputs. There is no streaming data path, so every pin is a level or strobe signal and there is no back-pressure. The count and the prescaler that drives it live outside this block.

Register select codes:
- 0: control. Bit 0 is the comparator enable, bit 1 the interrupt enable, bit 2 the auto-increment enable.
- 1: status. Writing with bit 0 set clears the event flag.
- 2: lower comparator half.
- 3: upper comparator half.
- 4: step.

Top module: `gcmp_compare_unit`

## Requirements
- R1: After reset, the comparator, step, event flag, the three control bits and the interrupt are all 0.
- R2: No event is recorded unless both `timer_en` and the comparator enable (control bit 0) are 1.
- R3: With both enables set, the event flag is set at the clock edge where the count is strictly greater than the comparator. A count equal to the comparator sets nothing.
- R4: The event flag is sticky. Only a write to select 1 with data bit 0 set clears it, and a write to select 1 with bit 0 clear leaves it unchanged.
- R5: On an event with auto-increment enabled (control bit 2) and a nonzero step, the comparator becomes comparator + ceil((count − comparator) / step) × step.
- R6: On an event with auto-increment disabled or a zero step, the comparator keeps its value.
- R7: `irq` is 1 exactly when the event flag and the interrupt enable (control bit 1) are both 1.
- R8: A write to select 2 replaces only comparator bits 31:0, and a write to select 3 replaces only bits 63:32.
- R9: A write to select 4 changes only the step. The comparator keeps its value until the next event uses the new step.
- R10: If a comparator write and an auto-increment fall on the same edge, the written half wins. If an event and a status clear fall on the same edge, the flag ends set.
- R11: The comparison is made again every cycle. A comparator write to a value below the running count sets the flag on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_en | input | 1 | Global timer enable shared by all ports |
| count | input | 64 | Shared free-running count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| cmp_val | output | 64 | Current comparator value |
| step_val | output | 32 | Current auto-increment step |
| cmp_en | output | 1 | Comparator enable bit |
| irq_en | output | 1 | Interrupt enable bit |
| auto_en | output | 1 | Auto-increment enable bit |
| evt_flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default widths: a 64-bit count, 32-bit data halves and a 32-bit step. These widths let the vectors place the comparator and count across the 32-bit half boundary and use the largest 32-bit step. The round-up arithmetic is then exercised with quotients above one and with differences wider than a single half. The directed part covers these cases:
- landing exactly on the count
- a zero step
- the same-edge collisions between an event and a comparator write or a status clear

// File: rtl/gcmp_pkg.sv
package gcmp_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL   = 3'd0,
    SEL_STATUS = 3'd1,
    SEL_CMP_LO = 3'd2,
    SEL_CMP_HI = 3'd3,
    SEL_STEP   = 3'd4
  } gcmp_sel_e;

  localparam int unsigned CTRL_CMP_BIT  = 0;
  localparam int unsigned CTRL_IRQ_BIT  = 1;
  localparam int unsigned CTRL_AUTO_BIT = 2;
  localparam int unsigned CTRL_W        = 3;
endpackage

// File: rtl/gcmp_ctrl_regs.sv
module gcmp_ctrl_regs
  import gcmp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STEP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmp_en,
  output logic              irq_en,
  output logic              auto_en,
  output logic [STEP_W-1:0] step
);
  localparam int unsigned TAKE_W = (STEP_W < DATA_W) ? STEP_W : DATA_W;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      step   <= '0;
    end else if (wr_en) begin
      if (wr_addr == SEL_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_addr == SEL_STEP) step   <= STEP_W'(wr_data[TAKE_W-1:0]);
    end
  end

  assign cmp_en  = ctrl_q[CTRL_CMP_BIT];
  assign irq_en  = ctrl_q[CTRL_IRQ_BIT];
  assign auto_en = ctrl_q[CTRL_AUTO_BIT];
endmodule

// File: rtl/gcmp_match.sv
module gcmp_match #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             timer_en,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp,
  output logic             hit
);
  always_comb hit = timer_en && cmp_en && (count > cmp);
endmodule

// File: rtl/gcmp_advance.sv
module gcmp_advance #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned STEP_W = 32
) (
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  cmp,
  input  logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  next_cmp
);
  localparam int unsigned WIDE_W = CNT_W + 1;

  logic [CNT_W-1:0]  gap;
  logic [WIDE_W-1:0] step_w;
  logic [WIDE_W-1:0] biased;
  logic [WIDE_W-1:0] quot;
  logic [WIDE_W-1:0] jump;

  always_comb begin
    gap      = count - cmp;
    step_w   = (step == '0) ? WIDE_W'(1) : WIDE_W'(step);
    biased   = {1'b0, gap} + step_w - WIDE_W'(1);
    quot     = biased / step_w;
    jump     = quot * step_w;
    next_cmp = cmp + jump[CNT_W-1:0];
  end
endmodule

// File: rtl/gcmp_compare_unit.sv
module gcmp_compare_unit
  import gcmp_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STEP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              timer_en,
  input  logic [CNT_W-1:0]  count,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cmp_val,
  output logic [STEP_W-1:0] step_val,
  output logic              cmp_en,
  output logic              irq_en,
  output logic              auto_en,
  output logic              evt_flag,
  output logic              irq
);
  localparam int unsigned HALVES = CNT_W / DATA_W;

  logic             hit;
  logic [CNT_W-1:0] adv_cmp;
  logic [CNT_W-1:0] cmp_d;
  logic [CNT_W-1:0] cmp_q;
  logic             flag_q;
  logic [HALVES-1:0] half_wr;

  gcmp_ctrl_regs #(.DATA_W(DATA_W), .STEP_W(STEP_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmp_en(cmp_en), .irq_en(irq_en),
    .auto_en(auto_en), .step(step_val)
  );

  gcmp_match #(.CNT_W(CNT_W)) match_i (
    .timer_en(timer_en), .cmp_en(cmp_en), .count(count),
    .cmp(cmp_q), .hit(hit)
  );

  gcmp_advance #(.CNT_W(CNT_W), .STEP_W(STEP_W)) adv_i (
    .count(count), .cmp(cmp_q), .step(step_val), .next_cmp(adv_cmp)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half_wr[h] = wr_en && (wr_addr == 3'(int'(SEL_CMP_LO) + h));
  end

  always_comb begin
    cmp_d = cmp_q;
    if (hit && auto_en && (step_val != '0)) cmp_d = adv_cmp;
    for (int h = 0; h < HALVES; h++) begin
      if (half_wr[h]) cmp_d[h*DATA_W +: DATA_W] = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      if (hit)
        flag_q <= 1'b1;
      else if (wr_en && (wr_addr == SEL_STATUS) && wr_data[0])
        flag_q <= 1'b0;
    end
  end

  assign cmp_val  = cmp_q;
  assign evt_flag = flag_q;
  assign irq      = flag_q && irq_en;
endmodule

// File: rtl/gcmp_chk.sv
module gcmp_chk #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              timer_en,
  input logic [CNT_W-1:0]  count,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  cmp_val,
  input logic              cmp_en,
  input logic              auto_en,
  input logic              evt_flag,
  input logic              irq
);
  logic clr_wr, cmp_wr, fire;
  assign clr_wr = wr_en && (wr_addr == 3'd1) && wr_data[0];
  assign cmp_wr = wr_en && ((wr_addr == 3'd2) || (wr_addr == 3'd3));
  assign fire   = timer_en && cmp_en && (count > cmp_val);

  // R2
  gate_needs_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> $past(timer_en && cmp_en));

  // R3
  rise_needs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> $past(count > cmp_val));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !clr_wr) |=> evt_flag);

  // R5
  advance_reaches_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && auto_en && (dut_step != '0) && !cmp_wr) |=> (cmp_val >= $past(count)));

  // R6
  hold_without_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !auto_en && !cmp_wr) |=> $stable(cmp_val));

  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_flag |-> !irq);

  logic [31:0] dut_step;
  assign dut_step = gcmp_compare_unit.step_val;
endmodule

bind gcmp_compare_unit gcmp_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .timer_en(timer_en), .count(count),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cmp_val(cmp_val),
  .cmp_en(cmp_en), .auto_en(auto_en), .evt_flag(evt_flag), .irq(irq)
);

// File: tb/gcmp_compare_unit_tb_top.sv
module gcmp_compare_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        timer_en = 1'b0;
  logic [63:0] count = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] cmp_val;
  logic [31:0] step_val;
  logic        cmp_en, irq_en, auto_en, evt_flag, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gcmp_compare_unit dut_i (
    .clk(clk), .rst_n(rst_n), .timer_en(timer_en), .count(count),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cmp_val(cmp_val),
    .step_val(step_val), .cmp_en(cmp_en), .irq_en(irq_en), .auto_en(auto_en),
    .evt_flag(evt_flag), .irq(irq)
  );

  typedef struct packed {
    logic [63:0] cmp;
    logic [31:0] step;
    logic [63:0] cnt;
    logic        auto_on;
    logic [63:0] exp_cmp;
    logic        exp_flag;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{64'd100, 32'd10, 64'd105, 1'b1, 64'd110, 1'b1},
    '{64'd100, 32'd10, 64'd110, 1'b1, 64'd110, 1'b1},
    '{64'd100, 32'd10, 64'd111, 1'b1, 64'd120, 1'b1},
    '{64'd100, 32'd0,  64'd150, 1'b1, 64'd100, 1'b1},
    '{64'd100, 32'd7,  64'd150, 1'b0, 64'd100, 1'b1},
    '{64'd100, 32'd10, 64'd100, 1'b1, 64'd100, 1'b0},
    '{64'h1_0000_0000, 32'd3, 64'h1_0000_0001, 1'b1, 64'h1_0000_0003, 1'b1},
    '{64'd5, 32'hFFFF_FFFF, 64'h2_0000_0000, 1'b1, 64'h2_0000_0003, 1'b1}
  };

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk64("R1 cmp", cmp_val, 64'd0);
    chk64("R1 step", {32'd0, step_val}, 64'd0);
    chk64("R1 ctrl", {61'd0, auto_en, irq_en, cmp_en}, 64'd0);
    chk64("R1 flag/irq", {62'd0, evt_flag, irq}, 64'd0);

    // R3 R5 R6 vector walk
    foreach (VECS[i]) begin
      wr(3'd0, 32'd0);
      wr(3'd1, 32'd1);
      wr(3'd2, VECS[i].cmp[31:0]);
      wr(3'd3, VECS[i].cmp[63:32]);
      wr(3'd4, VECS[i].step);
      wr(3'd0, {29'd0, VECS[i].auto_on, 2'b01});
      count = VECS[i].cnt;
      timer_en = 1'b1;
      @(negedge clk);
      timer_en = 1'b0;
      chk64($sformatf("R5 vec%0d cmp", i), cmp_val, VECS[i].exp_cmp);
      chk64($sformatf("R3 vec%0d flag", i), {63'd0, evt_flag}, {63'd0, VECS[i].exp_flag});
    end

    // R2 enables gate the event
    wr(3'd1, 32'd1);
    wr(3'd2, 32'd10); wr(3'd3, 32'd0);
    count = 64'd50;
    wr(3'd0, 32'd0);
    timer_en = 1'b1; @(negedge clk);
    chk64("R2 cmp_en off", {63'd0, evt_flag}, 64'd0);
    timer_en = 1'b0;
    wr(3'd0, 32'd1);
    @(negedge clk);
    chk64("R2 timer off", {63'd0, evt_flag}, 64'd0);

    // R7 interrupt masking
    timer_en = 1'b1; @(negedge clk); timer_en = 1'b0;
    chk64("R7 masked", {62'd0, evt_flag, irq}, 64'b10);
    wr(3'd0, 32'd3);
    chk64("R7 unmasked", {63'd0, irq}, 64'd1);

    // R4 sticky, write-one-to-clear
    wr(3'd1, 32'd0);
    chk64("R4 zero write", {63'd0, evt_flag}, 64'd1);
    wr(3'd1, 32'd1);
    chk64("R4 clear", {62'd0, evt_flag, irq}, 64'd0);

    // R8 halves
    wr(3'd2, 32'hAAAA_5555);
    wr(3'd3, 32'h1234_5678);
    wr(3'd2, 32'h0000_0077);
    chk64("R8 low only", cmp_val, 64'h1234_5678_0000_0077);
    wr(3'd3, 32'h0000_0009);
    chk64("R8 high only", cmp_val, 64'h0000_0009_0000_0077);

    // R9 step write leaves comparator
    wr(3'd4, 32'd25);
    chk64("R9 cmp kept", cmp_val, 64'h0000_0009_0000_0077);
    chk64("R9 step", {32'd0, step_val}, 64'd25);

    // R10 comparator write beats auto-increment
    wr(3'd3, 32'd0); wr(3'd2, 32'd10);
    wr(3'd0, 32'd5);
    count = 64'd20;
    timer_en = 1'b1;
    wr(3'd2, 32'd500);
    chk64("R10 write wins", cmp_val, 64'd500);
    chk64("R10 flag set", {63'd0, evt_flag}, 64'd1);
    timer_en = 1'b0;

    // R10 event beats clear
    wr(3'd0, 32'd1);
    wr(3'd2, 32'd10);
    timer_en = 1'b1;
    wr(3'd1, 32'd1);
    chk64("R10 set beats clear", {63'd0, evt_flag}, 64'd1);

    // R11 re-evaluation after a comparator write below the count
    wr(3'd2, 32'd900);
    wr(3'd1, 32'd1);
    chk64("R11 clear first", {63'd0, evt_flag}, 64'd0);
    wr(3'd2, 32'd5);
    chk64("R11 not yet", {63'd0, evt_flag}, 64'd0);
    @(negedge clk);
    chk64("R11 raised", {63'd0, evt_flag}, 64'd1);
    timer_en = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule